// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block raises an interrupt request for a small remote I/O port. It compares every pin that is configured as an input with a reference copy of the input register, the value the host last read. When any such pin differs from its reference bit, the block asserts a pull-down enable for an open-drain interrupt pad. The request is a level compare rather than a latched event. If the pin returns to its reference level, the request drops with no host action.

A serial-bus slave controller sits next to this block. It supplies a one-cycle strobe at the rising clock edge of each acknowledge or not-acknowledge bit. With that strobe come the direction of the current transfer, a flag saying whether this target was addressed, the current register pointer, and the input register value that was just shifted out. Only a strobe that ends a byte of a read from the input register, on a transfer addressed to this target, reloads the reference copy and clears the request.

After reset, the reference copy loads the pin values on the first enabled cycle. No interrupt is therefore raised at power-up when the pins are static. The pad driver and its pull-up are outside the block.

Top module: `input_change_irq`

## Requirements
- R1: When a pin whose direction bit is 1 (input) differs from its reference bit, `int_pull_en` goes to 1 at the next rising clock edge. `int_pull_en` is 1 only to pull the pad low and is 0 otherwise; the block has no drive-high output.
- R2: When every input pin matches its reference bit again, `int_pull_en` returns to 0 at the next clock edge, without any host access.
- R3: A qualified clear forces `int_pull_en` to 0 at the edge that samples it and loads `snap_in` into the reference. A qualified clear is `ack_edge`=1 together with `xfer_read`=1, `addr_hit`=1 and `reg_ptr`=0 (code 0 selects the input register). A pin change presented in that same cycle does not assert the request at that edge; it is reported one cycle later, if it still differs from the new reference.
- R4: A pin whose direction bit is 0 (output) never causes `int_pull_en` to assert, whatever its level.
- R5: Changing a direction bit from 0 to 1 asserts `int_pull_en` at the next edge if that pin's level differs from its reference bit.
- R6: A strobe with `addr_hit`=0 (a transfer to another target) leaves the reference and `int_pull_en` unchanged.
- R7: A strobe with `reg_ptr` other than 0 (a read of another register) leaves the reference and `int_pull_en` unchanged.
- R8: During reset `int_pull_en` is 0. After reset the reference takes the pin values on the first clock, so static pins raise no interrupt.
- R9: A strobe with `xfer_read`=0 (the acknowledge of a written byte) leaves the reference and `int_pull_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pin_in | input | PIN_W | Synchronized pin levels |
| cfg_dir | input | PIN_W | Direction per pin: 1 input, 0 output |
| snap_in | input | PIN_W | Input register value sent to the host in the byte being acknowledged |
| ack_edge | input | 1 | One-cycle strobe at the acknowledge/not-acknowledge clock rise |
| xfer_read | input | 1 | 1 when the current transfer is a read |
| addr_hit | input | 1 | 1 when the current transfer addresses this target |
| reg_ptr | input | PTR_W | Current register pointer; 0 selects the input register |
| int_pull_en | output | 1 | 1 enables the open-drain pull-down of the interrupt pad |

## Verification
A corrupted reference copy shows at `int_pull_en` one edge after the next compare. The output is then either stuck high on a matching input pin or silent on a changed one, and it stays wrong until a qualified clear reloads the reference. A clear qualifier that fires on the wrong strobe shows as a request that drops when it should not. The error then appears as a missing request one edge after a pin change that follows, because the reference has taken the wrong snapshot. A wrong priming flag shows within the first two cycles after reset as a spurious request on static pins.

// File: rtl/icid_pkg.sv
package icid_pkg;
  localparam int unsigned DEF_PIN_W = 8;
  localparam int unsigned DEF_PTR_W = 2;
  localparam int unsigned DEF_IN_REG_CODE = 0;
endpackage

// File: rtl/icid_rst_sync.sv
module icid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/icid_clear_qual.sv
module icid_clear_qual #(
  parameter int unsigned PTR_W       = icid_pkg::DEF_PTR_W,
  parameter int unsigned IN_REG_CODE = icid_pkg::DEF_IN_REG_CODE
) (
  input  logic             ack_edge,
  input  logic             xfer_read,
  input  logic             addr_hit,
  input  logic [PTR_W-1:0] reg_ptr,
  output logic             clr_fire
);
  localparam logic [PTR_W-1:0] InCode = PTR_W'(IN_REG_CODE);

  logic ptr_is_input;

  always_comb begin
    ptr_is_input = (reg_ptr == InCode);
    clr_fire     = ack_edge & xfer_read & addr_hit & ptr_is_input;
  end
endmodule

// File: rtl/icid_ref_store.sv
module icid_ref_store #(
  parameter int unsigned PIN_W = icid_pkg::DEF_PIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] snap_in,
  input  logic             load,
  output logic [PIN_W-1:0] ref_o,
  output logic             primed_o
);
  logic [PIN_W-1:0] ref_q, ref_d;
  logic             primed_q, primed_d;
  logic             ref_en;

  always_comb begin
    ref_en   = !primed_q || load;
    ref_d    = primed_q ? snap_in : pin_in;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      if (ref_en) ref_q <= ref_d;
      primed_q <= primed_d;
    end
  end

  assign ref_o    = ref_q;
  assign primed_o = primed_q;

  // Reference only moves on a qualified clear once primed (R6, R7, R9)
  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !load) |=> $stable(ref_q));

  // After the first enabled cycle the block stays primed (R8)
  assert_stay_primed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);
endmodule

// File: rtl/icid_irq_core.sv
module icid_irq_core #(
  parameter int unsigned PIN_W = icid_pkg::DEF_PIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] cfg_dir,
  input  logic [PIN_W-1:0] ref_in,
  input  logic             primed,
  input  logic             clr,
  output logic             irq_o
);
  logic [PIN_W-1:0] diff_bit;
  logic             any_diff;
  logic             irq_q, irq_d;

  for (genvar i = 0; i < PIN_W; i++) begin : g_cmp
    assign diff_bit[i] = (pin_in[i] ^ ref_in[i]) & cfg_dir[i];
  end

  always_comb begin
    any_diff = |diff_bit;
    irq_d    = primed & ~clr & any_diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // A qualified clear always drops the request (R3)
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);

  // No request before the reference has been primed (R8)
  assert_unprimed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !irq_q);
endmodule

// File: rtl/input_change_irq.sv
module input_change_irq #(
  parameter int unsigned PIN_W       = icid_pkg::DEF_PIN_W,
  parameter int unsigned PTR_W       = icid_pkg::DEF_PTR_W,
  parameter int unsigned IN_REG_CODE = icid_pkg::DEF_IN_REG_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] cfg_dir,
  input  logic [PIN_W-1:0] snap_in,
  input  logic             ack_edge,
  input  logic             xfer_read,
  input  logic             addr_hit,
  input  logic [PTR_W-1:0] reg_ptr,
  output logic             int_pull_en
);
  logic             rst_ns;
  logic             clr_fire;
  logic [PIN_W-1:0] ref_val;
  logic             primed;

  icid_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ns)
  );

  icid_clear_qual #(.PTR_W(PTR_W), .IN_REG_CODE(IN_REG_CODE)) u_qual (
    .ack_edge  (ack_edge),
    .xfer_read (xfer_read),
    .addr_hit  (addr_hit),
    .reg_ptr   (reg_ptr),
    .clr_fire  (clr_fire)
  );

  icid_ref_store #(.PIN_W(PIN_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_ns),
    .pin_in   (pin_in),
    .snap_in  (snap_in),
    .load     (clr_fire),
    .ref_o    (ref_val),
    .primed_o (primed)
  );

  icid_irq_core #(.PIN_W(PIN_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .pin_in  (pin_in),
    .cfg_dir (cfg_dir),
    .ref_in  (ref_val),
    .primed  (primed),
    .clr     (clr_fire),
    .irq_o   (int_pull_en)
  );

  // All pins as outputs: never a request (R4)
  assert_outputs_silent_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_dir == '0) |=> !int_pull_en);

  // Strobe for another target changes nothing on the output (R6)
  assert_foreign_strobe_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_edge && !addr_hit && int_pull_en && $stable(pin_in) && $stable(cfg_dir))
      |=> int_pull_en);
endmodule

// File: tb/input_change_irq_bench.sv
`timescale 1ns/1ps
module input_change_irq_bench;
  localparam int W = 8;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  pin_in, cfg_dir, snap_in;
  logic          ack_edge, xfer_read, addr_hit;
  logic [PW-1:0] reg_ptr;
  logic          int_pull_en;

  int checks = 0;
  int errors = 0;
  logic          m_exp;
  logic [W-1:0]  m_ref;
  bit            done = 0;

  always #2.5 clk = ~clk;

  input_change_irq #(.PIN_W(W), .PTR_W(PW)) u_input_change_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_dir(cfg_dir),
    .snap_in(snap_in), .ack_edge(ack_edge), .xfer_read(xfer_read),
    .addr_hit(addr_hit), .reg_ptr(reg_ptr), .int_pull_en(int_pull_en)
  );

  function automatic logic exp_irq(logic [W-1:0] p, logic [W-1:0] c,
                                   logic [W-1:0] r, logic clr);
    return !clr && (|((p ^ r) & c));
  endfunction

  function automatic logic is_clear(logic a, logic rd, logic hit, logic [PW-1:0] ptr);
    return a && rd && hit && (ptr == 0);
  endfunction

  task automatic check(string req, logic exp);
    checks++;
    if (int_pull_en !== exp) begin
      errors++;
      $display("FAIL %s: int_pull_en=%b expected %b at %0t", req, int_pull_en, exp, $time);
    end
  endtask

  // Called at a falling edge: apply inputs, advance one clock, check at next falling edge
  task automatic tick(string req, logic [W-1:0] p, logic [W-1:0] c,
                      logic a = 0, logic rd = 0, logic hit = 0,
                      logic [PW-1:0] ptr = 0, logic [W-1:0] s = '0);
    logic clr;
    pin_in = p; cfg_dir = c; ack_edge = a; xfer_read = rd;
    addr_hit = hit; reg_ptr = ptr; snap_in = s;
    clr   = is_clear(a, rd, hit, ptr);
    m_exp = exp_irq(p, c, m_ref, clr);
    if (clr) m_ref = s;
    @(posedge clk);
    @(negedge clk);
    check(req, m_exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] p, c;
    void'($urandom(32'd1357));
    rst_n = 0; pin_in = 8'h5A; cfg_dir = 8'hFF; snap_in = 0;
    ack_edge = 0; xfer_read = 0; addr_hit = 0; reg_ptr = 0;
    repeat (3) @(negedge clk);
    check("R8 in reset", 1'b0);
    rst_n = 1;
    m_ref = 8'h5A;
    for (int i = 0; i < 4; i++) tick("R8 static after reset", 8'h5A, 8'hFF);

    tick("R1 bit0 change", 8'h5B, 8'hFF);
    tick("R1 held", 8'h5B, 8'hFF);
    tick("R2 return to reference", 8'h5A, 8'hFF);

    tick("R1 bit7 change", 8'hDA, 8'hFF);
    tick("R3 clear with snapshot", 8'hDA, 8'hFF, 1, 1, 1, 0, 8'hDA);
    tick("R3 quiet after clear", 8'hDA, 8'hFF);

    tick("R1 change again", 8'h5A, 8'hFF);
    tick("R6 other target strobe", 8'h5A, 8'hFF, 1, 1, 0, 0, 8'h5A);
    tick("R7 other register read", 8'h5A, 8'hFF, 1, 1, 1, 2'd1, 8'h5A);
    tick("R7 config register read", 8'h5A, 8'hFF, 1, 1, 1, 2'd3, 8'h5A);
    tick("R9 write acknowledge", 8'h5A, 8'hFF, 1, 0, 1, 0, 8'h5A);
    tick("R9 still asserted", 8'h5A, 8'hFF);
    tick("R3 proper clear", 8'h5A, 8'hFF, 1, 1, 1, 0, 8'h5A);
    tick("R3 quiet", 8'h5A, 8'hFF);

    tick("R4 output pins toggle", 8'hA5 & 8'hF0 | 8'h0A, 8'h0F);
    tick("R4 outputs ignored", 8'hFA, 8'h0F);
    tick("R5 output to input", 8'hFA, 8'hFF);
    tick("R3 clear", 8'hFA, 8'hFF, 1, 1, 1, 0, 8'hFA);

    tick("R3 change during clear lost", 8'hFB, 8'hFF, 1, 1, 1, 0, 8'hFA);
    tick("R3 change reported next cycle", 8'hFB, 8'hFF);
    tick("R3 clear", 8'hFB, 8'hFF, 1, 1, 1, 0, 8'hFB);

    p = 8'hFB; c = 8'hFF;
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      if (r < 4) p = p ^ (8'd1 << $urandom_range(0, 7));
      if (r == 5) c = 8'($urandom);
      if (r >= 12)
        tick("R1 random clear mix", p, c, 1, 1'($urandom), 1'($urandom),
             2'($urandom), (r == 15) ? 8'($urandom) : p);
      else
        tick("R1 random", p, c);
    end

    done = 1;
    finish_run();
  end
endmodule